// File: doc/BRIEF.md
# Repeater Stack Expansion Bus Arbiter

This block is the shared-bus side of one repeater chip that sits in a stack of such chips. All chips in the stack share one data line and one jam line. A chip with local traffic asks an external arbiter for the bus by pulling an active-low request low. It drives the shared lines only after the arbiter answers with an active-low acknowledge. Every repeated bit crosses this bus, so a monitor attached to the bus sees all traffic in the stack.

When the chip is not the owner, it leaves both shared lines undriven and samples them as inputs. A shared active-low collision input is brought into the clock domain. If it is seen while this chip owns the bus, the jam line is held high for the rest of the activity period. The pads are modelled as separate input, output and output-enable signals, so the tri-state buffers stay outside the block.

Top module: `exp_arbiter`

## Requirements
- R1: While `rst` is high and on the first clock after it, `req_n` is 1 and `dat_oe`, `jam_oe`, `jam_o`, `dat_o`, `rx_dat` and `rx_jam` are all 0.
- R2: `req_n` goes to 0 on the first rising edge at which any bit of `port_rx` or `port_coll` is 1. It returns to 1 on the first edge at which all of those bits are 0.
- R3: `dat_oe` and `jam_oe` are never 1 while `req_n` is 1. The edge that first raises `req_n` low never also raises ownership, so ownership starts at least one clock after the request.
- R4: `ack_n` and `col_n` each pass through a chain of two flops. While the chip requests and `ack_n` is held low, the enables rise on the third edge after `ack_n` falls. They fall on the third edge after `ack_n` rises, and `req_n` stays low.
- R5: `dat_o` equals `tx_data` as sampled at the previous rising edge.
- R6: While the chip owns the bus, `col_n` held low raises `jam_o` on the third edge. `jam_o` then stays 1 until the activity ends, even after `col_n` returns high. A new activity period starts with `jam_o` at 0.
- R7: `rx_dat` and `rx_jam` hold `dat_i` and `jam_i` as registered at the previous edge when the chip was not the owner before that edge. They are 0 when it was the owner.
- R8: On the edge where activity ends, `req_n`, `dat_oe`, `jam_oe` and `jam_o` all return to idle together.
- R9: A port that is only colliding (`port_coll` bit set, `port_rx` bit clear) counts as activity and raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_rx | input | NPORTS | Per-port receive activity |
| port_coll | input | NPORTS | Per-port collision activity |
| tx_data | input | 1 | Local repeat data to put on the bus |
| ack_n | input | 1 | Active-low grant from the external arbiter (asynchronous) |
| col_n | input | 1 | Active-low shared collision (asynchronous) |
| dat_i | input | 1 | Shared data line as seen at the pad |
| jam_i | input | 1 | Shared jam line as seen at the pad |
| req_n | output | 1 | Active-low bus request |
| dat_o | output | 1 | Data driven to the pad |
| dat_oe | output | 1 | Data pad output enable |
| jam_o | output | 1 | Jam value driven to the pad |
| jam_oe | output | 1 | Jam pad output enable |
| rx_dat | output | 1 | Bus data received while not owner |
| rx_jam | output | 1 | Bus jam received while not owner |

## Verification
The bench counts edges through the synchronizers and checks that the enables stay low for exactly two clocks after the grant arrives. A design with one stage too few or too many would be off by a cycle. It clears the collision input after the jam begins. A jam that is not sticky would drop at that point, and a jam that is never cleared would show up at the start of the next activity. It starts an activity from a collision-only port while the grant is already held, which catches a design that ignores collisions as activity or takes the bus on the same edge as the request. It also drives the data pad while this chip owns the bus, which exposes a receive path that is not masked.

// File: rtl/exp_arbiter_pkg.sv
package exp_arbiter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2,
        ST_JAM  = 2'd3
    } exp_state_t;

    typedef struct packed {
        logic dat;
        logic jam;
    } exp_line_t;

    function automatic logic st_owns(exp_state_t s);
        return (s == ST_OWN) || (s == ST_JAM);
    endfunction

endpackage

// File: rtl/exp_sync.sv
module exp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/exp_own_fsm.sv
module exp_own_fsm
    import exp_arbiter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       grant,
    input  logic       coll,
    output exp_state_t state
);
    exp_state_t nxt;

    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_WAIT;
                ST_WAIT: nxt = grant ? ST_OWN : ST_WAIT;
                ST_OWN:  nxt = !grant ? ST_WAIT : (coll ? ST_JAM : ST_OWN);
                ST_JAM:  nxt = grant ? ST_JAM : ST_WAIT;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/exp_bus_io.sv
module exp_bus_io
    import exp_arbiter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      own,
    input  logic      tx_data,
    input  exp_line_t pad_in,
    output logic      dat_o,
    output exp_line_t rx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dat_o <= 1'b0;
            rx    <= '0;
        end else begin
            dat_o <= tx_data;
            rx    <= own ? '0 : pad_in;
        end
    end
endmodule

// File: rtl/exp_arbiter.sv
module exp_arbiter
    import exp_arbiter_pkg::*;
#(
    parameter int NPORTS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] port_rx,
    input  logic [NPORTS-1:0] port_coll,
    input  logic              tx_data,
    input  logic              ack_n,
    input  logic              col_n,
    input  logic              dat_i,
    input  logic              jam_i,
    output logic              req_n,
    output logic              dat_o,
    output logic              dat_oe,
    output logic              jam_o,
    output logic              jam_oe,
    output logic              rx_dat,
    output logic              rx_jam
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] async_in;
    logic [NSYNC-1:0] sync_out;
    logic             active;
    logic             own;
    exp_state_t       state;
    exp_line_t        pad_in;
    exp_line_t        rx;

    assign async_in = {~col_n, ~ack_n};
    assign active   = (|port_rx) | (|port_coll);

    exp_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_in),
        .q   (sync_out)
    );

    exp_own_fsm i_fsm (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .grant  (sync_out[0]),
        .coll   (sync_out[1]),
        .state  (state)
    );

    assign own        = st_owns(state);
    assign pad_in.dat = dat_i;
    assign pad_in.jam = jam_i;

    exp_bus_io i_io (
        .clk     (clk),
        .rst     (rst),
        .own     (own),
        .tx_data (tx_data),
        .pad_in  (pad_in),
        .dat_o   (dat_o),
        .rx      (rx)
    );

    assign req_n  = (state == ST_IDLE);
    assign dat_oe = own;
    assign jam_oe = own;
    assign jam_o  = (state == ST_JAM);
    assign rx_dat = rx.dat;
    assign rx_jam = rx.jam;
endmodule

// File: rtl/exp_arbiter_chk.sv
module exp_arbiter_chk #(
    parameter int NPORTS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NPORTS-1:0] port_rx,
    input logic [NPORTS-1:0] port_coll,
    input logic              req_n,
    input logic              dat_oe,
    input logic              jam_o,
    input logic              jam_oe,
    input logic              rx_dat,
    input logic              rx_jam
);
    AST_REQ_TRACKS_ACT: assert property (@(posedge clk) disable iff (rst || $past(rst))
        req_n == !($past(|port_rx) || $past(|port_coll)));  // R2
    AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (dat_oe || jam_oe) |-> !req_n);  // R3
    AST_OWN_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe) |-> $past(!req_n));  // R3
    AST_JAM_OWNED: assert property (@(posedge clk) disable iff (rst)
        jam_o |-> jam_oe);  // R6
    AST_JAM_STICKY: assert property (@(posedge clk) disable iff (rst)
        jam_o |=> (jam_o || !jam_oe));  // R6
    AST_RX_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(dat_oe) |-> (!rx_dat && !rx_jam));  // R7
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_n) |-> (!dat_oe && !jam_oe && !jam_o));  // R8
endmodule

bind exp_arbiter exp_arbiter_chk #(.NPORTS(NPORTS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .port_rx   (port_rx),
    .port_coll (port_coll),
    .req_n     (req_n),
    .dat_oe    (dat_oe),
    .jam_o     (jam_o),
    .jam_oe    (jam_oe),
    .rx_dat    (rx_dat),
    .rx_jam    (rx_jam)
);

// File: tb/test_exp_arbiter.sv
`timescale 1ns/1ps
module test_exp_arbiter;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] port_rx = '0;
    logic [NP-1:0] port_coll = '0;
    logic          tx_data = 1'b0;
    logic          ack_n = 1'b1;
    logic          col_n = 1'b1;
    logic          dat_i = 1'b0;
    logic          jam_i = 1'b0;
    logic          req_n, dat_o, dat_oe, jam_o, jam_oe, rx_dat, rx_jam;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] val;   // req_n,dat_o,dat_oe,jam_o,jam_oe,rx_dat,rx_jam
        string      tag;
    } exp_item_t;

    exp_item_t sb[$];

    always #10 clk = ~clk;

    exp_arbiter i_exp_arbiter (
        .clk(clk), .rst(rst), .port_rx(port_rx), .port_coll(port_coll),
        .tx_data(tx_data), .ack_n(ack_n), .col_n(col_n), .dat_i(dat_i),
        .jam_i(jam_i), .req_n(req_n), .dat_o(dat_o), .dat_oe(dat_oe),
        .jam_o(jam_o), .jam_oe(jam_oe), .rx_dat(rx_dat), .rx_jam(rx_jam)
    );

    // driver: wait one rising edge, then push what the outputs must be
    task automatic tick_expect(input logic rq, input logic d, input logic oe,
                               input logic j, input logic rd, input logic rj,
                               input string tag);
        exp_item_t it;
        @(posedge clk);
        #1;
        it.val = {rq, d, oe, j, oe, rd, rj};
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_item_t it;
            logic [6:0] act;
            it  = sb.pop_front();
            act = {req_n, dat_o, dat_oe, jam_o, jam_oe, rx_dat, rx_jam};
            total++;
            if (act !== it.val) begin
                bad++;
                $display("FAIL %s actual=%b expected=%b (req_n,dat_o,dat_oe,jam_o,jam_oe,rx_dat,rx_jam)",
                         it.tag, act, it.val);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        tick_expect(1, 0, 0, 0, 0, 0, "R1 reset held");
        at_neg(); rst = 1'b0;
        tick_expect(1, 0, 0, 0, 0, 0, "R1 first clock after reset");

        // idle: receive path follows pads
        at_neg(); dat_i = 1'b1; jam_i = 1'b1;
        tick_expect(1, 0, 0, 0, 1, 1, "R7 idle receive");

        // activity on port 3, no grant yet
        at_neg(); port_rx[3] = 1'b1;
        tick_expect(0, 0, 0, 0, 1, 1, "R2 request on activity");
        tick_expect(0, 0, 0, 0, 1, 1, "R3 no drive without grant");

        // grant arrives
        at_neg(); ack_n = 1'b0; dat_i = 1'b0; jam_i = 1'b0;
        tick_expect(0, 0, 0, 0, 0, 0, "R4 grant edge 1");
        tick_expect(0, 0, 0, 0, 0, 0, "R4 grant edge 2");
        tick_expect(0, 0, 1, 0, 0, 0, "R4 grant edge 3 owns");

        // receive masked while owning
        at_neg(); dat_i = 1'b1; jam_i = 1'b1;
        tick_expect(0, 0, 1, 0, 0, 0, "R7 receive masked while owner");

        // transmit data
        at_neg(); tx_data = 1'b1;
        tick_expect(0, 1, 1, 0, 0, 0, "R5 data one");
        at_neg(); tx_data = 1'b0;
        tick_expect(0, 0, 1, 0, 0, 0, "R5 data zero");

        // collision
        at_neg(); col_n = 1'b0;
        tick_expect(0, 0, 1, 0, 0, 0, "R6 collision edge 1");
        tick_expect(0, 0, 1, 0, 0, 0, "R6 collision edge 2");
        tick_expect(0, 0, 1, 1, 0, 0, "R6 jam on edge 3");
        at_neg(); col_n = 1'b1;
        tick_expect(0, 0, 1, 1, 0, 0, "R6 jam sticky 1");
        tick_expect(0, 0, 1, 1, 0, 0, "R6 jam sticky 2");
        tick_expect(0, 0, 1, 1, 0, 0, "R6 jam sticky 3");

        // activity ends, grant still held
        at_neg(); port_rx = '0; dat_i = 1'b0; jam_i = 1'b0;
        tick_expect(1, 0, 0, 0, 0, 0, "R8 release on end of activity");

        // collision-only activity with grant already present
        at_neg(); port_coll[0] = 1'b1;
        tick_expect(0, 0, 0, 0, 0, 0, "R9 collision-only requests");
        tick_expect(0, 0, 1, 0, 0, 0, "R3 owns one clock after request, R6 jam cleared");

        // grant removed mid-activity
        at_neg(); ack_n = 1'b1;
        tick_expect(0, 0, 1, 0, 0, 0, "R4 release edge 1");
        tick_expect(0, 0, 1, 0, 0, 0, "R4 release edge 2");
        tick_expect(0, 0, 0, 0, 0, 0, "R4 release edge 3, request kept");

        at_neg(); port_coll = '0;
        tick_expect(1, 0, 0, 0, 0, 0, "R2 request drops");

        at_neg();
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule